// File: doc/BRIEF.md
# Multi-mode PWM channel bank

This block drives a small bank of pulse-width modulated outputs. All channels share one phase counter. A programmable clock divider sets how fast the counter advances, and a resolution field sets how many phase bits are in use. A smaller resolution gives a shorter period with coarser duty steps. A larger resolution gives a longer period with finer steps. Each channel compares the phase against its current duty level. Each channel also has its own enable bit and its own polarity-invert bit.

Each channel has a mode state machine that sets its current duty level. The machine runs only when the phase counter wraps, so a new level always starts on a fresh period. The states are:

- `ST_STEADY` holds level A.
- `ST_BLINK_A` and `ST_BLINK_B` alternate between level A and level B, holding each for a programmable number of periods.
- `ST_RAMP_UP` and `ST_RAMP_DOWN` step the level linearly between A and B, which gives a heartbeat-style ramp.

The transitions between these states are:

- `ST_STEADY` goes to `ST_RAMP_UP` when heartbeat is enabled, and to `ST_BLINK_A` when only blink is enabled.
- `ST_BLINK_A` goes to `ST_BLINK_B` after the hold count, and `ST_BLINK_B` goes back to `ST_BLINK_A` the same way.
- `ST_RAMP_UP` goes to `ST_RAMP_DOWN` once the level reaches B.
- `ST_RAMP_DOWN` goes to `ST_RAMP_UP` once the level reaches A.
- Any state returns to `ST_STEADY` when its mode is switched off.

Heartbeat takes priority over blink.

Software configures the block through a single-cycle write port. Setting a lock bit freezes every register until the next reset.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads as zero, the lock is clear, every output is low, and every channel is in `ST_STEADY` with duty level 0.
- R2: The phase counter advances once every div+1 clocks. It counts from 0 to 2^(res+1)-1 and then wraps to 0, so one PWM period lasts (div+1)*2^(res+1) clocks.
- R3: An enabled, non-inverted channel in steady mode is high while the phase is below level A. This gives (div+1)*min(A, 2^(res+1)) high clocks per period.
- R4: The invert bit flips a channel's output. A disabled channel holds its output constantly at its invert bit value.
- R5: In blink mode a channel alternates between level A and level B. It spends hold+1 whole periods on each level.
- R6: In heartbeat mode a channel starts at level A. Every interval+1 periods the level rises by step, clamping at B, and then falls by step, clamping at A, repeating without end. Heartbeat overrides blink when both are enabled.
- R7: A channel's duty level changes only on the clock where the phase counter wraps, so every period carries a single level.
- R8: Writing 1 to bit 0 of address 2 sets the lock. While the lock is set, every write is ignored. Only reset clears the lock.
- R9: The register map is as follows.
  - Address 0 holds div in bits [7:0] and res in bits [10:8].
  - Address 1 holds the enable bits at [3:0], invert at [7:4], blink at [11:8] and heartbeat at [15:12], with bit n belonging to channel n within each field.
  - Each channel c has three registers starting at base 8+4c:
    - base+0 holds A in bits [7:0] and B in bits [15:8].
    - base+1 holds hold in bits [7:0] and interval in bits [15:8].
    - base+2 holds step in bits [7:0].
- R10: Channels are independent. Each output depends only on its own level, enable and invert settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | NCH | One modulated output per channel |

## Verification
A table of steady-mode settings varies divider, resolution, level, enable and invert on two channels at once. It tells apart period-length errors, saturation above full scale, polarity errors and any crosstalk between channels. The blink pattern is checked as a sequence of per-period high counts aligned to the period start. This separates a wrong hold length, mid-period switching and a stuck level. The heartbeat pattern, with blink also enabled, must produce the exact ramp 16, 32, 48, 32, 16. This exposes wrong clamping, a wrong step direction and a wrong mode priority. Writes made after locking, followed by a reset, show that the lock freezes the settings and that only reset releases it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    parameter int DUTY_W = 8;
    parameter int CNT_W  = 8;
    parameter int DIV_W  = 8;
    parameter int RES_W  = 3;

    typedef enum logic [2:0] {
        ST_STEADY,
        ST_BLINK_A,
        ST_BLINK_B,
        ST_RAMP_UP,
        ST_RAMP_DOWN
    } mode_state_e;

    typedef struct packed {
        logic [DUTY_W-1:0] lvl_a;
        logic [DUTY_W-1:0] lvl_b;
        logic [CNT_W-1:0]  hold;
        logic [CNT_W-1:0]  interval;
        logic [DUTY_W-1:0] step;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [RES_W-1:0]  res_q,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    inv_q,
    output logic [NCH-1:0]    blink_q,
    output logic [NCH-1:0]    hb_q,
    output chan_cfg_t         cfg_q [NCH],
    output logic              lock_q
);
    localparam logic [ADDR_W-1:0] ADR_GLB  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_MODE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_LOCK = ADDR_W'(2);
    localparam int CH_BASE   = 8;
    localparam int CH_STRIDE = 4;

    logic wr_ok;
    assign wr_ok = wr_en && !lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            res_q   <= '0;
            en_q    <= '0;
            inv_q   <= '0;
            blink_q <= '0;
            hb_q    <= '0;
            lock_q  <= 1'b0;
        end else if (wr_ok) begin
            if (wr_addr == ADR_GLB) begin
                div_q <= wr_data[DIV_W-1:0];
                res_q <= wr_data[8 +: RES_W];
            end
            if (wr_addr == ADR_MODE) begin
                en_q    <= wr_data[0 +: NCH];
                inv_q   <= wr_data[4 +: NCH];
                blink_q <= wr_data[8 +: NCH];
                hb_q    <= wr_data[12 +: NCH];
            end
            if (wr_addr == ADR_LOCK) begin
                lock_q <= wr_data[0];
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan_regs
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + CH_STRIDE * c);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[c] <= '0;
            end else if (wr_ok) begin
                if (wr_addr == BASE) begin
                    cfg_q[c].lvl_a <= wr_data[7:0];
                    cfg_q[c].lvl_b <= wr_data[15:8];
                end
                if (wr_addr == BASE + ADDR_W'(1)) begin
                    cfg_q[c].hold     <= wr_data[7:0];
                    cfg_q[c].interval <= wr_data[15:8];
                end
                if (wr_addr == BASE + ADDR_W'(2)) begin
                    cfg_q[c].step <= wr_data[7:0];
                end
            end
        end
    end

    // R8: lock is sticky until reset
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R8: settings frozen while locked
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(div_q) && $stable(res_q) && $stable(en_q)
                    && $stable(inv_q) && $stable(blink_q) && $stable(hb_q)));
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic [RES_W-1:0]  res,
    output logic [DUTY_W-1:0] phase_q,
    output logic              wrap
);
    localparam int SPAN_W = DUTY_W + 1;

    logic [DIV_W-1:0]  div_cnt_q;
    logic [SPAN_W-1:0] span;
    logic [DUTY_W-1:0] top;
    logic              tick;

    assign span = SPAN_W'(1) << (32'(res) + 1);
    assign top  = DUTY_W'(span - SPAN_W'(1));
    assign tick = (div_cnt_q >= div);
    assign wrap = tick && (phase_q >= top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
            phase_q   <= '0;
        end else begin
            div_cnt_q <= tick ? '0 : div_cnt_q + DIV_W'(1);
            if (wrap)      phase_q <= '0;
            else if (tick) phase_q <= phase_q + DUTY_W'(1);
        end
    end

    // R2: phase only moves on a divider tick
    p_phase_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase_q));
    // R2: a wrap always returns the phase to zero
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (phase_q == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  chan_cfg_t         cfg,
    input  logic              blink_en,
    input  logic              hb_en,
    output logic [DUTY_W-1:0] duty_q
);
    mode_state_e       state_q, state_d;
    logic [DUTY_W-1:0] duty_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DUTY_W:0]   up_sum, dn_lim;

    assign up_sum = {1'b0, duty_q} + {1'b0, cfg.step};
    assign dn_lim = {1'b0, cfg.lvl_a} + {1'b0, cfg.step};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STEADY;
            duty_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            duty_q  <= duty_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        duty_d  = duty_q;
        cnt_d   = cnt_q;
        if (wrap) begin
            unique case (state_q)
                ST_STEADY: begin
                    duty_d = cfg.lvl_a;
                    cnt_d  = '0;
                    if (hb_en)         state_d = ST_RAMP_UP;
                    else if (blink_en) state_d = ST_BLINK_A;
                end
                ST_BLINK_A, ST_BLINK_B: begin
                    if (!blink_en || hb_en) begin
                        state_d = ST_STEADY;
                        duty_d  = cfg.lvl_a;
                        cnt_d   = '0;
                    end else if (cnt_q >= cfg.hold) begin
                        cnt_d   = '0;
                        state_d = (state_q == ST_BLINK_A) ? ST_BLINK_B : ST_BLINK_A;
                        duty_d  = (state_q == ST_BLINK_A) ? cfg.lvl_b : cfg.lvl_a;
                    end else begin
                        cnt_d  = cnt_q + CNT_W'(1);
                        duty_d = (state_q == ST_BLINK_A) ? cfg.lvl_a : cfg.lvl_b;
                    end
                end
                ST_RAMP_UP: begin
                    if (!hb_en) begin
                        state_d = ST_STEADY;
                        duty_d  = cfg.lvl_a;
                        cnt_d   = '0;
                    end else if (cnt_q >= cfg.interval) begin
                        cnt_d = '0;
                        if (up_sum >= {1'b0, cfg.lvl_b}) begin
                            duty_d  = cfg.lvl_b;
                            state_d = ST_RAMP_DOWN;
                        end else begin
                            duty_d = up_sum[DUTY_W-1:0];
                        end
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_RAMP_DOWN: begin
                    if (!hb_en) begin
                        state_d = ST_STEADY;
                        duty_d  = cfg.lvl_a;
                        cnt_d   = '0;
                    end else if (cnt_q >= cfg.interval) begin
                        cnt_d = '0;
                        if ({1'b0, duty_q} <= dn_lim) begin
                            duty_d  = cfg.lvl_a;
                            state_d = ST_RAMP_UP;
                        end else begin
                            duty_d = duty_q - cfg.step;
                        end
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_d = ST_STEADY;
                    duty_d  = cfg.lvl_a;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // R7: duty level only moves on a phase wrap
    p_duty_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_q));
    // R7: state only moves on a phase wrap
    p_state_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(state_q));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic [NCH-1:0]    pwm_out
);
    logic [DIV_W-1:0]  div;
    logic [RES_W-1:0]  res;
    logic [NCH-1:0]    en, inv, blink, hb;
    chan_cfg_t         cfg [NCH];
    logic              lock;
    logic [DUTY_W-1:0] phase;
    logic              wrap;

    pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_q(div), .res_q(res), .en_q(en),
        .inv_q(inv), .blink_q(blink), .hb_q(hb), .cfg_q(cfg), .lock_q(lock)
    );

    pwm_phase u_phase (
        .clk(clk), .rst_n(rst_n), .div(div), .res(res),
        .phase_q(phase), .wrap(wrap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [DUTY_W-1:0] duty;
        pwm_chan u_chan (
            .clk(clk), .rst_n(rst_n), .wrap(wrap), .cfg(cfg[c]),
            .blink_en(blink[c]), .hb_en(hb[c]), .duty_q(duty)
        );
        assign pwm_out[c] = inv[c] ^ (en[c] && (phase < duty));
    end
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwm_bank #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    typedef struct packed {
        int a0; int a1; int res; int div; int en; int inv;
        int per; int e0; int e1;
    } vec_t;

    // steady-mode vectors: expected high clocks per period (R2 R3 R4 R9 R10)
    localparam vec_t VEC [6] = '{
        '{64,  128, 7, 0, 3, 0, 256, 64,  128},
        '{10,  40,  4, 2, 3, 0, 96,  30,  96},
        '{100, 0,   7, 0, 3, 1, 256, 156, 0},
        '{100, 20,  7, 0, 2, 1, 256, 256, 20},
        '{5,   3,   2, 3, 3, 2, 32,  20,  20},
        '{0,   255, 7, 0, 1, 0, 256, 0,   0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 5'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int ch, input int n, output int cnt);
        cnt = 0;
        repeat (n) begin
            @(negedge clk);
            cnt += int'(pwm_out[ch]);
        end
    endtask

    task automatic align(input int ch);
        logic p;
        @(negedge clk);
        p = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (!p && pwm_out[ch]) break;
            p = pwm_out[ch];
        end
    endtask

    task automatic periods(input int ch, output int c [8]);
        for (int k = 0; k < 8; k++) c[k] = 0;
        for (int s = 0; s < 8 * 256; s++) begin
            if (s > 0) @(negedge clk);
            c[s / 256] += int'(pwm_out[ch]);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int cnt, c0, c1, start;
        int c [8];
        do_reset();

        // R1: reset state
        @(negedge clk);
        chk(pwm_out == '0, "R1 outputs low after reset", int'(pwm_out), 0);
        measure(0, 300, cnt);
        chk(cnt == 0, "R1 ch0 stays low with reset config", cnt, 0);
        measure(1, 300, cnt);
        chk(cnt == 0, "R1 ch1 stays low with reset config", cnt, 0);

        // table of steady-mode vectors
        for (int v = 0; v < 6; v++) begin
            wr(0, (VEC[v].res << 8) | VEC[v].div);
            wr(1, (VEC[v].inv << 4) | VEC[v].en);
            wr(8, VEC[v].a0);
            wr(12, VEC[v].a1);
            repeat (1000) @(negedge clk);
            measure(0, VEC[v].per, c0);
            chk(c0 == VEC[v].e0, $sformatf("R2 R3 R4 R9 vec%0d ch0", v), c0, VEC[v].e0);
            measure(1, VEC[v].per, c1);
            chk(c1 == VEC[v].e1, $sformatf("R10 R3 R4 vec%0d ch1", v), c1, VEC[v].e1);
        end

        // R5 R7: blink between 64 and 192, two periods each
        wr(0, 16'h0700);
        wr(8, 16'hC040);
        wr(9, 16'h0001);
        wr(12, 0);
        wr(1, 16'h0101);
        repeat (1500) @(negedge clk);
        align(0);
        periods(0, c);
        for (int k = 0; k < 8; k++)
            chk(c[k] == 64 || c[k] == 192, $sformatf("R7 blink period %0d whole level", k), c[k], 64);
        for (int k = 0; k < 4; k++)
            chk(c[k] == c[k+4], $sformatf("R5 blink repeats every 4 periods at %0d", k), c[k+4], c[k]);
        for (int k = 0; k < 4; k++)
            chk(c[k] != c[k+2], $sformatf("R5 blink level flips after hold at %0d", k), c[k+2], 256 - c[k]);

        // R6: heartbeat 16..48 step 16, with blink also set (heartbeat wins)
        wr(8, 16'h3010);
        wr(9, 16'h0001);
        wr(10, 16'h0010);
        wr(1, 16'h1101);
        repeat (2000) @(negedge clk);
        align(0);
        periods(0, c);
        start = -1;
        for (int k = 3; k >= 0; k--) if (c[k] == 16) start = k;
        chk(start >= 0, "R6 heartbeat reaches level A", start, 0);
        if (start < 0) start = 0;
        chk(c[start+1] == 32, "R6 heartbeat rising step", c[start+1], 32);
        chk(c[start+2] == 48, "R6 heartbeat clamps at B", c[start+2], 48);
        chk(c[start+3] == 32, "R6 heartbeat falling step", c[start+3], 32);
        chk(c[start+4] == 16, "R6 heartbeat returns to A", c[start+4], 16);

        // R8: lock freezes settings
        do_reset();
        wr(0, 16'h0700);
        wr(1, 16'h0001);
        wr(8, 16'h0040);
        wr(2, 1);
        wr(8, 16'h00C8);
        wr(0, 16'h0200);
        wr(2, 0);
        repeat (800) @(negedge clk);
        measure(0, 256, cnt);
        chk(cnt == 64, "R8 writes ignored while locked", cnt, 64);
        wr(1, 16'h0000);
        repeat (600) @(negedge clk);
        measure(0, 256, cnt);
        chk(cnt == 64, "R8 enable write ignored while locked", cnt, 64);

        // R8 R1: reset clears the lock
        do_reset();
        @(negedge clk);
        chk(pwm_out == '0, "R1 outputs low after second reset", int'(pwm_out), 0);
        wr(0, 16'h0700);
        wr(1, 16'h0001);
        wr(8, 16'h00C8);
        repeat (800) @(negedge clk);
        measure(0, 256, cnt);
        chk(cnt == 200, "R8 reset releases lock", cnt, 200);

        finish_run();
    end
endmodule